// File: doc/BRIEF.md
# Programmable AND-OR Plane for a Ten-Output Logic Array

This block is the combinational core of a small programmable logic array. Twelve dedicated inputs and ten feedback signals each supply a true column and an inverted column. Together these make 44 array columns. A flat configuration vector defines every product-term row. In that vector, a set bit connects a column to the row's AND gate and a cleared bit isolates the column.

From the rows the block produces four groups of outputs:
- ten sum terms;
- ten output-enable terms;
- one shared asynchronous-clear term and one shared synchronous-set term;
- the two per-output mode bits that are stored in the same vector.

The downstream output cells consume all of these. The number of logic rows per output varies across the ten outputs, and the vector follows one fixed linear layout. No clock is involved, and no storage or handshake exists at either edge.

Top module: `pla_sop_array`

## Requirements
- R1: Column 2k of a row carries input k true and column 2k+1 carries it inverted. Inputs 0..11 are `ded_in[0..11]` and inputs 12..21 are `fb_in[0..9]`. Within a row, fuse bit c belongs to column c. A bit value of 1 connects the column and 0 isolates it. A row is true exactly when every connected column is 1.
- R2: A row with all 44 bits set is always false, whatever the inputs.
- R3: A row with all 44 bits cleared is always true.
- R4: `ar_o` is the row at fuse bits 0..43.
- R5: Output blocks start at bit 44 and are laid out in output order.
  - Block j holds one enable row followed by T(j) logic rows.
  - T is 8,10,12,14,16,16,14,12,10,8 for outputs 0..9.
  - `oe_o[j]` is that enable row.
- R6: `sum_o[j]` is the OR of the T(j) logic rows of block j only. The enable row never contributes to it.
- R7: `sp_o` is the row at fuse bits 5764..5807.
- R8: `mode_s0_o[j]` equals fuse bit 5808+2j and `mode_s1_o[j]` equals fuse bit 5809+2j. The map is 5828 bits wide.
- R9: Every output follows its inputs combinationally, with no clock and no retained state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fuse_map | input | 5828 | Flat configuration vector, 1 = connected |
| ded_in | input | 12 | Dedicated array inputs |
| fb_in | input | 10 | Feedback signals from the output cells |
| sum_o | output | 10 | Sum term per output |
| oe_o | output | 10 | Output-enable term per output |
| ar_o | output | 1 | Shared asynchronous-clear term |
| sp_o | output | 1 | Shared synchronous-set term |
| mode_s0_o | output | 10 | First mode bit per output |
| mode_s1_o | output | 10 | Second mode bit per output |

## Verification
The assertions check three things whenever the inputs settle:
- the true and inverted columns of each input disagree;
- fully connected rows are false and fully isolated rows are true;
- an enable row that is true while every logic row is false never raises the sum.

The fuse layout cannot be seen by any local property: which bit offsets land in which row, the uneven row counts, and the placement of the set row and the mode bits. Only the bench can show these. It compares a behavioural model against the outputs on randomized vectors, and also drives rows programmed at the block boundaries.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int DEF_DED       = 12;
  localparam int DEF_FB        = 10;
  localparam int DEF_OUT       = 10;
  localparam int DEF_MIN_TERMS = 8;
  localparam int DEF_STEP      = 2;

  // logic rows for output j: rises by step toward the middle, symmetric
  function automatic int terms_of(input int j, input int n_out,
                                  input int min_t, input int step);
    int d;
    d = (j < (n_out - 1 - j)) ? j : (n_out - 1 - j);
    return min_t + step * d;
  endfunction

  // first fuse of output block j (block 0 sits after the clear row)
  function automatic int block_base(input int j, input int n_out,
                                    input int min_t, input int step,
                                    input int cols);
    int acc;
    acc = cols;
    for (int i = 0; i < j; i++)
      acc += (terms_of(i, n_out, min_t, step) + 1) * cols;
    return acc;
  endfunction

  function automatic int set_base(input int n_out, input int min_t,
                                  input int step, input int cols);
    return block_base(n_out, n_out, min_t, step, cols);
  endfunction

  function automatic int mode_base(input int n_out, input int min_t,
                                   input int step, input int cols);
    return set_base(n_out, min_t, step, cols) + cols;
  endfunction

  function automatic int fuse_total(input int n_out, input int min_t,
                                    input int step, input int cols);
    return mode_base(n_out, min_t, step, cols) + 2 * n_out;
  endfunction
endpackage

// File: rtl/pla_col_drive.sv
module pla_col_drive #(
  parameter int N_DED = 12,
  parameter int N_FB  = 10,
  localparam int N_SIG = N_DED + N_FB,
  localparam int COLS  = 2 * N_SIG
) (
  input  logic [N_DED-1:0] ded_in,
  input  logic [N_FB-1:0]  fb_in,
  output logic [COLS-1:0]  cols
);
  logic [N_SIG-1:0] sig;
  assign sig = {fb_in, ded_in};

  for (genvar k = 0; k < N_SIG; k++) begin : g_col
    assign cols[2*k]   = sig[k];
    assign cols[2*k+1] = ~sig[k];
  end

  // R1: each true/inverted column pair must disagree
  always_comb begin
    if (!$isunknown(sig))
      for (int k = 0; k < N_SIG; k++)
        a_r1_col_pair_differs: assert (cols[2*k] != cols[2*k+1]);
  end
endmodule

// File: rtl/pla_pterm.sv
module pla_pterm #(
  parameter int COLS = 44
) (
  input  logic [COLS-1:0] fuses,
  input  logic [COLS-1:0] cols,
  output logic            term
);
  // isolated columns read as 1; connected columns pass their value
  assign term = &(cols | ~fuses);

  always_comb begin
    if (!$isunknown({fuses, cols})) begin
      if (&fuses)
        a_r2_full_row_false: assert (!term);
      if (!(|fuses))
        a_r3_empty_row_true: assert (term);
    end
  end
endmodule

// File: rtl/pla_out_block.sv
module pla_out_block #(
  parameter int COLS  = 44,
  parameter int TERMS = 8,
  localparam int ROWS  = TERMS + 1,
  localparam int WIDTH = ROWS * COLS
) (
  input  logic [WIDTH-1:0] fuses,
  input  logic [COLS-1:0]  cols,
  output logic             sum,
  output logic             oe
);
  logic [ROWS-1:0] row_hit;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    pla_pterm #(.COLS(COLS)) u_row (
      .fuses (fuses[r*COLS +: COLS]),
      .cols  (cols),
      .term  (row_hit[r])
    );
  end

  // row 0 of the block is the enable row; the rest feed the OR
  assign oe  = row_hit[0];
  assign sum = |row_hit[ROWS-1:1];

  always_comb begin
    if (!$isunknown({fuses, cols}) && oe && !(|row_hit[ROWS-1:1]))
      a_r6_enable_not_summed: assert (!sum);
  end
endmodule

// File: rtl/pla_sop_array.sv
module pla_sop_array #(
  parameter int N_DED     = pla_pkg::DEF_DED,
  parameter int N_FB      = pla_pkg::DEF_FB,
  parameter int N_OUT     = pla_pkg::DEF_OUT,
  parameter int MIN_TERMS = pla_pkg::DEF_MIN_TERMS,
  parameter int STEP      = pla_pkg::DEF_STEP,
  localparam int COLS     = 2 * (N_DED + N_FB),
  localparam int SET_AT   = pla_pkg::set_base(N_OUT, MIN_TERMS, STEP, COLS),
  localparam int MODE_AT  = pla_pkg::mode_base(N_OUT, MIN_TERMS, STEP, COLS),
  localparam int N_FUSE   = pla_pkg::fuse_total(N_OUT, MIN_TERMS, STEP, COLS)
) (
  input  logic [N_FUSE-1:0] fuse_map,
  input  logic [N_DED-1:0]  ded_in,
  input  logic [N_FB-1:0]   fb_in,
  output logic [N_OUT-1:0]  sum_o,
  output logic [N_OUT-1:0]  oe_o,
  output logic              ar_o,
  output logic              sp_o,
  output logic [N_OUT-1:0]  mode_s0_o,
  output logic [N_OUT-1:0]  mode_s1_o
);
  logic [COLS-1:0] cols;

  pla_col_drive #(.N_DED(N_DED), .N_FB(N_FB)) u_cols (
    .ded_in (ded_in),
    .fb_in  (fb_in),
    .cols   (cols)
  );

  pla_pterm #(.COLS(COLS)) u_clear_row (
    .fuses (fuse_map[0 +: COLS]),
    .cols  (cols),
    .term  (ar_o)
  );

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    localparam int TERMS = pla_pkg::terms_of(j, N_OUT, MIN_TERMS, STEP);
    localparam int BASE  = pla_pkg::block_base(j, N_OUT, MIN_TERMS, STEP, COLS);

    pla_out_block #(.COLS(COLS), .TERMS(TERMS)) u_blk (
      .fuses (fuse_map[BASE +: (TERMS + 1) * COLS]),
      .cols  (cols),
      .sum   (sum_o[j]),
      .oe    (oe_o[j])
    );

    assign mode_s0_o[j] = fuse_map[MODE_AT + 2*j];
    assign mode_s1_o[j] = fuse_map[MODE_AT + 2*j + 1];
  end

  pla_pterm #(.COLS(COLS)) u_set_row (
    .fuses (fuse_map[SET_AT +: COLS]),
    .cols  (cols),
    .term  (sp_o)
  );

  // R2: an unprogrammed map must hold every product output low
  always_comb begin
    if (!$isunknown({ded_in, fb_in}) && (&fuse_map))
      a_r2_blank_map_quiet: assert (!(|{sum_o, oe_o, ar_o, sp_o}));
  end
endmodule

// File: tb/pla_sop_array_test.sv
module pla_sop_array_test;
  localparam int NF = 5828;
  localparam int NC = 44;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [NF-1:0] fz;
  logic [11:0]   dv;
  logic [9:0]    fv;
  logic [9:0]    sum_o, oe_o, s0_o, s1_o;
  logic          ar_o, sp_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  pla_sop_array uut (
    .fuse_map (fz), .ded_in (dv), .fb_in (fv),
    .sum_o (sum_o), .oe_o (oe_o), .ar_o (ar_o), .sp_o (sp_o),
    .mode_s0_o (s0_o), .mode_s1_o (s1_o)
  );

  // behavioural reference
  int tcount [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

  function automatic int blk_start(int j);
    int p = NC;
    for (int i = 0; i < j; i++) p += (tcount[i] + 1) * NC;
    return p;
  endfunction

  function automatic bit col_val(int c);
    int k = c / 2;
    bit v = (k < 12) ? dv[k] : fv[k - 12];
    return (c % 2) ? !v : v;
  endfunction

  function automatic bit row_val(int base);
    for (int c = 0; c < NC; c++)
      if (fz[base + c] && !col_val(c)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string req, string what, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [9:0] es, eo, e0, e1;
    for (int j = 0; j < 10; j++) begin
      int b = blk_start(j);
      eo[j] = row_val(b);
      es[j] = 1'b0;
      for (int r = 1; r <= tcount[j]; r++) es[j] |= row_val(b + r * NC);
      e0[j] = fz[5808 + 2*j];
      e1[j] = fz[5809 + 2*j];
    end
    chk("R6", "sum_o", sum_o, es);
    chk("R5", "oe_o", oe_o, eo);
    chk("R4", "ar_o", {9'b0, ar_o}, {9'b0, row_val(0)});
    chk("R7", "sp_o", {9'b0, sp_o}, {9'b0, row_val(5764)});
    chk("R8", "mode_s0_o", s0_o, e0);
    chk("R8", "mode_s1_o", s1_o, e1);
  endtask

  // apply after a rising edge, compare at the following falling edge
  task automatic step();
    @(negedge clk);
    compare_all();
    @(posedge clk);
    #1;
  endtask

  task automatic sparse_map(int one_in);
    for (int i = 0; i < NF; i++) fz[i] = (($urandom % one_in) == 0);
  endtask

  initial begin
    int base;
    fz = '1; dv = '0; fv = '0;
    @(posedge clk); #1;

    // R2: blank map, reset state -- all products low, mode bits high
    for (int n = 0; n < 4; n++) begin
      dv = 12'($urandom); fv = 10'($urandom);
      step();
      chk("R2", "blank sum|oe", sum_o | oe_o, 10'h0);
    end

    // R3: everything isolated -- every row true, mode bits low
    fz = '0;
    step();
    chk("R3", "empty rows sum", sum_o, 10'h3ff);
    chk("R3", "empty rows ar/sp", {8'b0, ar_o, sp_o}, 10'h3);

    // R1/R6: one logic row of output 4 = ded[3] & ~fb[7], enable row isolated
    fz = '1;
    base = blk_start(4);
    for (int c = 0; c < NC; c++) fz[base + c] = 1'b0;
    base = base + tcount[4] * NC;
    for (int c = 0; c < NC; c++) fz[base + c] = 1'b0;
    fz[base + 6] = 1'b1;
    fz[base + 2*19 + 1] = 1'b1;
    for (int p = 0; p < 4; p++) begin
      dv = 12'h0; fv = 10'h0;
      dv[3] = p[0]; fv[7] = p[1];
      step();
      chk("R1", "single row and", {9'b0, sum_o[4]}, {9'b0, p[0] & !p[1]});
      chk("R6", "enable row excluded", {9'b0, oe_o[4]}, 10'h1);
    end

    // R4/R7 boundaries: clear row and set row alone isolated
    fz = '1;
    for (int c = 0; c < NC; c++) fz[c] = 1'b0;
    step();
    chk("R4", "clear row only", {8'b0, ar_o, sp_o}, 10'h2);
    chk("R5", "bit 44 still connected", oe_o, 10'h0);
    fz = '1;
    for (int c = 0; c < NC; c++) fz[5764 + c] = 1'b0;
    step();
    chk("R7", "set row only", {8'b0, ar_o, sp_o}, 10'h1);
    chk("R6", "bit 5763 still connected", sum_o, 10'h0);

    // R8: walking mode bits
    for (int j = 0; j < 10; j++) begin
      fz = '1;
      fz[5808 + 2*j] = 1'b0;
      step();
      chk("R8", "s0 walk", s0_o, ~(10'h1 << j));
      chk("R8", "s1 untouched", s1_o, 10'h3ff);
    end

    // R5/R6/R9: random maps, inputs changed every cycle
    for (int m = 0; m < 40; m++) begin
      sparse_map((m % 2) ? 16 : 28);
      for (int n = 0; n < 8; n++) begin
        dv = 12'($urandom); fv = 10'($urandom);
        step();
      end
    end

    // R9: output follows an input change within the same cycle
    fz = '1;
    for (int c = 0; c < NC; c++) fz[c] = 1'b0;
    fz[0] = 1'b1;
    dv = 12'h0;
    #1 chk("R9", "ar low", {9'b0, ar_o}, 10'h0);
    dv[0] = 1'b1;
    #1 chk("R9", "ar follows input", {9'b0, ar_o}, 10'h1);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule